// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block holds the status register and write-enable latch of a serial flash slave, and runs its self-timed status write. A host drives chip select low and clocks bytes in on the serial input in SPI mode 0 (data sampled on the rising serial clock, MSB first). The block decodes three byte-wide commands: set write enable (0x06), read status (0x05) and write status (0x01). A write-status command carries one data byte. It is committed only when the full frame is exactly sixteen bits long. When it is committed, a busy period of `T_WRITE` system clocks starts. The write-enable latch clears when that period ends.

All serial pins are sampled with the system clock through a synchronizer, so the serial clock must be several times slower than the system clock. The interface is a fixed single-bit serial link with no flow control, so it carries no valid/ready handshake. Every pin is plain and is sampled every system clock. Two inputs change how a write behaves. The write-protect pin, together with the protect bit, blocks status writes. The OTP-mode input sends a write to a sticky lock flag and leaves the register untouched.

Top module: `sfsr_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, `otp_lock_o` is 0 and `sdo_o` is 0.
- R2: A frame holding exactly the 8 bits of opcode 0x06 sets the write-enable flag (status bit 1) when chip select rises, unless a write cycle is running.
- R3: After opcode 0x05, the status byte is shifted out on `sdo_o` MSB first, with each bit changing after a serial-clock fall, and it repeats for as long as chip select stays low. Bit 6 always reads 0.
- R4: A frame of opcode 0x01 followed by data byte D, exactly 16 bits long and with the write-enable flag set, loads status bit 7 from D[7] and bits 5..2 from D[5:2]. D[6], D[1] and D[0] are ignored.
- R5: A write-status frame of any length other than 16 bits has no effect, and the write-enable flag stays set.
- R6: A write-status frame sent while the write-enable flag is clear has no effect.
- R7: An accepted write sets the busy flag (status bit 0) for `T_WRITE` system clocks. It then clears the busy flag and the write-enable flag together.
- R8: While busy, the status register can be read, and a write-status frame is ignored even though the write-enable flag is still set.
- R9: When status bit 7 is 1 and `wpn_i` is low, a write-status frame is ignored and the write-enable flag stays set. With `wpn_i` high, the same register can be rewritten.
- R10: With `otp_mode_i` high, an accepted write-status frame leaves status bits 7 and 5..2 unchanged, sets `otp_lock_o` to 1 and still runs the busy period.
- R11: `otp_lock_o` stays 1 until reset, whatever the later mode or commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out (status readback) |
| wpn_i | input | 1 | Active-low write-protect pin |
| otp_mode_i | input | 1 | Redirects status writes to the lock flag |
| otp_lock_o | output | 1 | Sticky one-time lock flag |

## Verification
The write path is swept over all 256 data bytes. This separates the bits that must land in the register from the three that must be dropped. The status is read twice for each byte, once in the middle of the busy period and once after it, which tells the commit time apart from the time the write-enable flag clears. Frames of 15 and 17 bits, a frame sent without write enable and a frame sent during the busy period each try one gating rule on its own. The protect-pin pair and the OTP-mode case set the lock-flag path apart from the normal register update.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam int SRP_BIT = 7;
  localparam int BP_HI   = 5;
  localparam int BP_LO   = 2;
  localparam int BP_W    = BP_HI - BP_LO + 1;
endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic sdi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic cs_low,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_q, cs_q, di_q;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      di_q  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck};
      cs_q  <= {cs_q[STAGES-2:0], csn};
      di_q  <= {di_q[STAGES-2:0], sdi};
      sck_d <= sck_q[STAGES-1];
      cs_d  <= cs_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign cs_rise  = cs_q[STAGES-1] & ~cs_d;
  assign cs_fall  = ~cs_q[STAGES-1] & cs_d;
  assign cs_low   = ~cs_q[STAGES-1];
  assign sdi_s    = di_q[STAGES-1];
endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame
  import sfsr_pkg::*;
#(
  localparam int CNT_MAX = 2 * BYTE_W + 1,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             cs_fall,
  input  logic             cs_low,
  input  logic             sdi_s,
  output logic [7:0]       opcode,
  output logic [7:0]       data,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             op_done
);
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      opcode  <= '0;
      bit_cnt <= '0;
      op_done <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (cs_fall) begin
        sh      <= '0;
        opcode  <= '0;
        bit_cnt <= '0;
      end else if (sck_rise && cs_low) begin
        sh <= {sh[6:0], sdi_s};
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          opcode  <= {sh[6:0], sdi_s};
          op_done <= 1'b1;
        end
      end
    end
  end

  assign data = sh;
endmodule

// File: rtl/sfsr_regs.sv
module sfsr_regs
  import sfsr_pkg::*;
#(
  parameter int T_WRITE = 1000,
  parameter int CNT_W   = 5,
  localparam int TMR_W  = $clog2(T_WRITE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [7:0]       opcode,
  input  logic             new_srp,
  input  logic [BP_W-1:0]  new_bp,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             wpn,
  input  logic             otp_mode,
  output logic [7:0]       status,
  output logic             otp_lock
);
  logic            srp, wel, busy;
  logic [BP_W-1:0] bp;
  logic [TMR_W-1:0] tmr;
  logic hw_locked, wren_go, wrsr_go;

  assign hw_locked = srp & ~wpn;
  assign wren_go = frame_end && !busy && opcode == OP_WREN
                   && bit_cnt == CNT_W'(BYTE_W);
  assign wrsr_go = frame_end && !busy && wel && !hw_locked
                   && opcode == OP_WRSR && bit_cnt == CNT_W'(2 * BYTE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srp      <= 1'b0;
      bp       <= '0;
      wel      <= 1'b0;
      busy     <= 1'b0;
      tmr      <= '0;
      otp_lock <= 1'b0;
    end else if (busy) begin
      if (tmr == '0) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end else if (wrsr_go) begin
      busy <= 1'b1;
      tmr  <= TMR_W'(T_WRITE - 1);
      if (otp_mode) begin
        otp_lock <= 1'b1;
      end else begin
        srp <= new_srp;
        bp  <= new_bp;
      end
    end else if (wren_go) begin
      wel <= 1'b1;
    end
  end

  assign status = {srp, 1'b0, bp, wel, busy};
endmodule

// File: rtl/sfsr_ctrl.sv
module sfsr_ctrl
  import sfsr_pkg::*;
#(
  parameter int T_WRITE     = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2 * BYTE_W + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic sdi_i,
  output logic sdo_o,
  input  logic wpn_i,
  input  logic otp_mode_i,
  output logic otp_lock_o
);
  logic sck_rise, sck_fall, cs_rise, cs_fall, cs_low, sdi_s;
  logic [7:0] opcode, data, status_w, snap;
  logic [CNT_W-1:0] bit_cnt;
  logic op_done, rd_active;
  logic [2:0] tx_idx;
  logic unused_data_bits;

  sfsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck_i), .csn(csn_i), .sdi(sdi_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .cs_low(cs_low), .sdi_s(sdi_s)
  );

  sfsr_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_fall(cs_fall),
    .cs_low(cs_low), .sdi_s(sdi_s), .opcode(opcode), .data(data),
    .bit_cnt(bit_cnt), .op_done(op_done)
  );

  assign unused_data_bits = ^{data[6], data[1:0]};

  sfsr_regs #(.T_WRITE(T_WRITE), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_end(cs_rise), .opcode(opcode),
    .new_srp(data[SRP_BIT]), .new_bp(data[BP_HI:BP_LO]), .bit_cnt(bit_cnt),
    .wpn(wpn_i), .otp_mode(otp_mode_i), .status(status_w),
    .otp_lock(otp_lock_o)
  );

  // Readback: a fresh snapshot at the start of every byte keeps the busy flag live.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      tx_idx    <= '0;
      snap      <= '0;
      sdo_o     <= 1'b0;
    end else if (cs_rise || cs_fall) begin
      rd_active <= 1'b0;
      tx_idx    <= '0;
      sdo_o     <= 1'b0;
    end else begin
      if (op_done && opcode == OP_RDSR) rd_active <= 1'b1;
      if (sck_fall && rd_active) begin
        tx_idx <= tx_idx + 1'b1;
        if (tx_idx == '0) begin
          snap  <= status_w;
          sdo_o <= status_w[7];
        end else begin
          sdo_o <= snap[3'd7 - tx_idx];
        end
      end
    end
  end
endmodule

// File: rtl/sfsr_ctrl_chk.sv
module sfsr_ctrl_chk #(
  parameter int T_WRITE = 1000,
  localparam int W = $clog2(T_WRITE + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wpn_i,
  input logic       otp_mode_i,
  input logic [7:0] status_w,
  input logic       otp_lock_o
);
  logic [W-1:0] busy_len;
  logic [4:0] prot;
  assign prot = {status_w[7], status_w[5:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (status_w[0]) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  p_bit6_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status_w[6]);
  p_wip_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_w[0]) |-> $past(status_w[1]));
  p_wel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_w[0]) |-> !status_w[1]);
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[0] |-> busy_len < W'(T_WRITE));
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[0] |=> $stable(prot));
  p_hw_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w[7] && !wpn_i) |=> $stable(prot));
  p_otp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    otp_mode_i |=> $stable(prot));
  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    otp_lock_o |=> otp_lock_o);
endmodule

bind sfsr_ctrl sfsr_ctrl_chk #(.T_WRITE(T_WRITE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wpn_i(wpn_i), .otp_mode_i(otp_mode_i),
  .status_w(status_w), .otp_lock_o(otp_lock_o)
);

// File: tb/sfsr_ctrl_bench.sv
module sfsr_ctrl_bench;
  localparam int TW   = 128;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0, wpn = 1'b1, otp = 1'b0;
  logic sdo, lock;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sfsr_ctrl #(.T_WRITE(TW)) u_sfsr_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .wpn_i(wpn), .otp_mode_i(otp), .otp_lock_o(lock)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] bits, input int n, output logic [31:0] rx);
    rx = '0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0;
      sdi = bits[i];
      wait_clk(HALF);
      rx = {rx[30:0], sdo};
      sck = 1'b1;
      wait_clk(HALF);
    end
    sck = 1'b0;
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic wren();
    logic [31:0] rx;
    frame(32'h06, 8, rx);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [31:0] rx;
    frame({16'h0, 8'h01, d}, 16, rx);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [31:0] rx;
    frame(32'h0500, 16, rx);
    s = rx[7:0];
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  initial begin
    logic [7:0] s;
    logic [31:0] rx;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk("R1 sdo", {7'b0, sdo}, 8'h00);
    chk("R1 lock", {7'b0, lock}, 8'h00);
    rdsr(s); chk("R1 status", s, 8'h00);
    // R6 write without write enable
    wrsr(8'hBC); wait_clk(TW + 10);
    rdsr(s); chk("R6 no wel", s, 8'h00);
    // R2 / R3 write enable then repeated readback
    wren();
    frame(32'h050000, 24, rx);
    chk("R2 wel set", rx[15:8], 8'h02);
    chk("R3 repeat byte", rx[7:0], 8'h02);
    // R5 wrong frame lengths
    frame({17'h0, 8'h01, 7'h5E}, 15, rx);
    wait_clk(TW + 10);
    rdsr(s); chk("R5 15 bits", s, 8'h02);
    frame({15'h0, 8'h01, 8'hBC, 1'b1}, 17, rx);
    wait_clk(TW + 10);
    rdsr(s); chk("R5 17 bits", s, 8'h02);
    // R4 / R7 / R8 sweep of every data byte
    for (int d = 0; d < 256; d++) begin
      wren();
      wrsr(8'(d));
      rdsr(s); chk("R7 busy read R8", s, (8'(d) & 8'hBC) | 8'h03);
      wait_clk(TW);
      rdsr(s); chk("R4 data R7 wel clear", s, 8'(d) & 8'hBC);
    end
    // R8 write during busy ignored
    wren(); wrsr(8'h08); wrsr(8'h3C);
    wait_clk(TW + 20);
    rdsr(s); chk("R8 busy write ignored", s, 8'h08);
    // R9 hardware lock
    wren(); wrsr(8'h80); wait_clk(TW + 10);
    rdsr(s); chk("R9 srp set", s, 8'h80);
    wpn = 1'b0;
    wren(); wrsr(8'h3C); wait_clk(TW + 10);
    rdsr(s); chk("R9 locked", s, 8'h82);
    wpn = 1'b1;
    wrsr(8'h14); wait_clk(TW + 10);
    rdsr(s); chk("R9 unlocked", s, 8'h14);
    // R10 / R11 OTP redirect
    otp = 1'b1;
    wren(); wrsr(8'hA0);
    rdsr(s); chk("R10 otp busy", s, 8'h17);
    chk("R10 lock set", {7'b0, lock}, 8'h01);
    wait_clk(TW);
    rdsr(s); chk("R10 bits kept", s, 8'h14);
    otp = 1'b0;
    wren(); wrsr(8'h20); wait_clk(TW + 10);
    rdsr(s); chk("R11 normal write", s, 8'h20);
    chk("R11 lock sticky", {7'b0, lock}, 8'h01);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule